// File: doc/BRIEF.md
# Bus-Master DMA Address and Count Unit

This block follows one bus-master DMA buffer transfer for a network controller. It holds a 32-bit system-memory address. The address steps by one each time the bus interface unit issues an address-increment command, so sequential transfers land on sequential addresses. Next to it sits a 12-bit byte counter. The counter holds the two's complement of the bytes still to move in the current transmit or receive buffer. It counts up by one per transferred byte. When it wraps to zero, the buffer is finished: the block raises a one-cycle done pulse and ignores further byte increments until the counter is loaded again.

A small state machine watches bus ownership. It runs two limits at the same time: a cycle timer and a burst-transfer counter. When ownership starts with the timer enabled, the machine moves from `ST_IDLE` to `ST_HOLD`. From `ST_HOLD` it moves to `ST_YIELD` as soon as either limit is reached, whichever comes first. In `ST_YIELD` it asks for bus release. It returns to `ST_IDLE` once ownership ends. It also goes straight from `ST_HOLD` back to `ST_IDLE` if ownership ends or the timer is disabled.

A host register port reaches all four registers. The port works only while the controller's stop input is high. A test-step input changes what a host write does: a write to the address or byte counter makes one increment step, and a write to the burst counter makes one decrement step.

Top module: `dma_xfer_unit`

## Requirements
- R1: After reset, `bus_release` and `buf_done` are low, the machine is in `ST_IDLE`, and byte increments are blocked until the byte counter is first written.
- R2: Register select 0 is the address. A plain host write loads it. Each cycle with `inc_addr` high and no host write to it adds one, wrapping from FFFFFFFF to 00000000.
- R3: Register select 1 is the byte counter. A plain write loads the counter from write data bits 11:0 and ignores bits 31:12. A read returns the counter in bits 11:0, ones in bits 15:12 and zeros in bits 31:16.
- R4: Each cycle with `inc_cnt` high adds one to the byte counter. On the edge where it wraps from FFF to 000, `buf_done` goes high for exactly one cycle. After that, `inc_cnt` has no effect until the next write.
- R5: With `test_step` high, a host write to select 0 or select 1 adds one to that register, and the write data is ignored.
- R6: Select 3 is the 8-bit burst counter. A plain write loads it. With `test_step` high, a write subtracts one from it.
- R7: Select 2 is the 16-bit cycle limit L. If L is nonzero and the burst limit is not reached first, `bus_release` rises exactly L cycles after the edge that enters `ST_HOLD`. It stays high until `bus_own` falls, and it is low from the following edge.
- R8: In `ST_HOLD`, each cycle with `xfer` high takes one from a nonzero burst counter. The transfer that takes it from 1 to 0 moves the machine to `ST_YIELD`, so `bus_release` is high from the next edge.
- R9: While `stop` is low, host writes change nothing and `host_rdata` is zero.
- R10: While `timer_en` is low, `bus_release` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop | input | 1 | Controller stopped; enables host access |
| test_step | input | 1 | Turns host writes into step operations |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select: 0 address, 1 byte count, 2 cycle limit, 3 burst count |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational |
| inc_addr | input | 1 | Address increment command |
| inc_cnt | input | 1 | Byte-count increment command |
| xfer | input | 1 | One transfer completed on the bus |
| bus_own | input | 1 | Controller currently owns the bus |
| timer_en | input | 1 | Enables the bus-activity limits |
| bus_release | output | 1 | Request to give up the bus |
| buf_done | output | 1 | One-cycle pulse when the byte count wraps to zero |

## Verification
The register path is tried with plain loads, with test-step writes, and with loads that carry junk in the reserved upper bits. These separate loading from stepping and show that bits 31:12 of a byte-count write have no effect. The byte counter is taken through a short countdown to its wrap and then given extra increments, which separates the wrap pulse from the blocking that follows it. Bus release is tried three ways: the cycle limit alone, a burst limit that is reached before the cycle limit, and the timer disabled. This shows which limit triggered the release and on which edge it appeared.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_BCNT  = 2'd1,
        SEL_LIMIT = 2'd2,
        SEL_BURST = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_YIELD = 2'd2
    } bus_state_e;
endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_step,
    input  logic [AW-1:0] wr_data,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (wr_en) begin
            addr <= wr_step ? addr + 1'b1 : wr_data;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/dma_byte_cnt.sv
module dma_byte_cnt #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_step,
    input  logic [CW-1:0] wr_data,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          done
);
    localparam logic [CW-1:0] LAST = '1;

    logic halt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            halt <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (wr_en && !wr_step) begin
                cnt  <= wr_data;
                halt <= 1'b0;
            end else if (wr_en || (inc && !halt)) begin
                cnt  <= cnt + 1'b1;
                halt <= (cnt == LAST);
                done <= (cnt == LAST);
            end
        end
    end
endmodule

// File: rtl/dma_bus_timer.sv
module dma_bus_timer
    import dma_xfer_pkg::*;
#(
    parameter int TW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          timer_en,
    input  logic          bus_own,
    input  logic          xfer,
    input  logic          lim_wr,
    input  logic [TW-1:0] lim_data,
    input  logic          bst_wr,
    input  logic          bst_step,
    input  logic [BW-1:0] bst_data,
    output logic [TW-1:0] lim,
    output logic [BW-1:0] bst,
    output logic          bus_release
);
    bus_state_e state, state_nx;
    logic [TW-1:0] tmr;
    logic          tmr_hit, bst_hit, holding;

    assign tmr_hit = (lim != '0) && (TW'(tmr + 1'b1) == lim);
    assign bst_hit = xfer && (bst == BW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (bus_own && timer_en) state_nx = ST_HOLD;
            ST_HOLD: begin
                if (!bus_own || !timer_en)  state_nx = ST_IDLE;
                else if (tmr_hit || bst_hit) state_nx = ST_YIELD;
            end
            ST_YIELD: if (!bus_own) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_release = 1'b0;
        holding     = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_HOLD:  holding = 1'b1;
            ST_YIELD: bus_release = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
            lim <= '0;
            bst <= '0;
        end else begin
            tmr <= holding ? tmr + 1'b1 : '0;
            if (lim_wr) lim <= lim_data;
            if (bst_wr)
                bst <= bst_step ? bst - 1'b1 : bst_data;
            else if (holding && xfer && bst != '0)
                bst <= bst - 1'b1;
        end
    end
endmodule

// File: rtl/dma_xfer_unit.sv
module dma_xfer_unit
    import dma_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12,
    parameter int TW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop,
    input  logic          test_step,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    host_sel,
    input  logic [AW-1:0] host_wdata,
    output logic [AW-1:0] host_rdata,
    input  logic          inc_addr,
    input  logic          inc_cnt,
    input  logic          xfer,
    input  logic          bus_own,
    input  logic          timer_en,
    output logic          bus_release,
    output logic          buf_done
);
    localparam int FW  = 16;
    localparam int RSV = FW - CW;

    logic          wr_ok;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic [TW-1:0] lim_q;
    logic [BW-1:0] bst_q;
    reg_sel_e      sel;

    assign sel   = reg_sel_e'(host_sel);
    assign wr_ok = host_wr && stop;

    dma_addr_reg #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_ok && sel == SEL_ADDR), .wr_step(test_step),
        .wr_data(host_wdata), .inc(inc_addr), .addr(addr_q)
    );

    dma_byte_cnt #(.CW(CW)) u_bcnt (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_ok && sel == SEL_BCNT), .wr_step(test_step),
        .wr_data(host_wdata[CW-1:0]), .inc(inc_cnt),
        .cnt(cnt_q), .done(buf_done)
    );

    dma_bus_timer #(.TW(TW), .BW(BW)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .timer_en(timer_en), .bus_own(bus_own), .xfer(xfer),
        .lim_wr(wr_ok && sel == SEL_LIMIT), .lim_data(host_wdata[TW-1:0]),
        .bst_wr(wr_ok && sel == SEL_BURST), .bst_step(test_step),
        .bst_data(host_wdata[BW-1:0]),
        .lim(lim_q), .bst(bst_q), .bus_release(bus_release)
    );

    always_comb begin
        host_rdata = '0;
        if (stop && host_rd) begin
            unique case (sel)
                SEL_ADDR:  host_rdata = addr_q;
                SEL_BCNT:  host_rdata = {{(AW-FW){1'b0}}, {RSV{1'b1}}, cnt_q};
                SEL_LIMIT: host_rdata = {{(AW-TW){1'b0}}, lim_q};
                SEL_BURST: host_rdata = {{(AW-BW){1'b0}}, bst_q};
                default:   host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop,
    input logic          host_wr,
    input logic          host_rd,
    input logic [1:0]    host_sel,
    input logic [AW-1:0] host_rdata,
    input logic          inc_addr,
    input logic          bus_own,
    input logic          timer_en,
    input logic          bus_release,
    input logic          buf_done,
    input logic [AW-1:0] addr_q,
    input logic [CW-1:0] cnt_q
);
    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_addr && !(host_wr && stop && host_sel == 2'd0)) |=> addr_q == $past(addr_q) + 1'b1);
    // R3
    rsv_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && host_rd && host_sel == 2'd1) |-> (host_rdata[15:12] == 4'hF && host_rdata[31:16] == 16'h0));
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |=> !buf_done);
    // R4
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> cnt_q == '0);
    // R9
    quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop |-> host_rdata == '0);
    // R10
    release_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_release) |-> $past(timer_en));
    // R7
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_release && !bus_own) |=> !bus_release);
endmodule

bind dma_xfer_unit dma_xfer_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop(stop), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_rdata(host_rdata), .inc_addr(inc_addr),
    .bus_own(bus_own), .timer_en(timer_en), .bus_release(bus_release),
    .buf_done(buf_done), .addr_q(addr_q), .cnt_q(cnt_q)
);

// File: tb/sim_dma_xfer_unit.sv
`timescale 1ns/1ps
module sim_dma_xfer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop = 1'b1, test_step = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        inc_addr = 1'b0, inc_cnt = 1'b0, xfer = 1'b0;
    logic        bus_own = 1'b0, timer_en = 1'b0;
    logic        bus_release, buf_done;
    int          total = 0, bad = 0;
    bit          ended = 1'b0;

    always #10 clk = ~clk;

    dma_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .stop(stop), .test_step(test_step),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .inc_addr(inc_addr), .inc_cnt(inc_cnt), .xfer(xfer),
        .bus_own(bus_own), .timer_en(timer_en),
        .bus_release(bus_release), .buf_done(buf_done)
    );

    // {sel, test_step, write data, expected read}
    localparam logic [66:0] VEC [0:9] = '{
        {2'd0, 1'b0, 32'h1234_5678, 32'h1234_5678},  // R2 load
        {2'd0, 1'b1, 32'hDEAD_BEEF, 32'h1234_5679},  // R5 step
        {2'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R2 load
        {2'd0, 1'b1, 32'h0000_0000, 32'h0000_0000},  // R5 step wraps
        {2'd1, 1'b0, 32'h0000_0123, 32'h0000_F123},  // R3
        {2'd1, 1'b0, 32'hFFFF_0ABC, 32'h0000_FABC},  // R3 upper ignored
        {2'd1, 1'b1, 32'h0000_0777, 32'h0000_FABD},  // R5 step
        {2'd3, 1'b0, 32'h0000_0005, 32'h0000_0005},  // R6 load
        {2'd3, 1'b1, 32'h0000_0009, 32'h0000_0004},  // R6 decrement
        {2'd2, 1'b0, 32'h0000_0010, 32'h0000_0010}   // R7 limit load
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic tst, input logic [31:0] d);
        host_sel = sel; test_step = tst; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0; test_step = 1'b0;
    endtask

    task automatic hread(input logic [1:0] sel, output logic [31:0] d);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        host_rd = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        @(negedge clk); step(); step();
        // R1 reset state
        check("R1 bus_release", {31'd0, bus_release}, 32'd0);
        check("R1 buf_done", {31'd0, buf_done}, 32'd0);
        rst_n = 1'b1;
        step();
        inc_cnt = 1'b1; step(); inc_cnt = 1'b0;
        hread(2'd1, rd);
        check("R1 count blocked before load", rd, 32'h0000_F000);

        foreach (VEC[i]) begin
            hwrite(VEC[i][66:65], VEC[i][64], VEC[i][63:32]);
            hread(VEC[i][66:65], rd);
            check($sformatf("R2/R3/R5/R6 vector %0d", i), rd, VEC[i][31:0]);
        end

        // R9: writes ignored and reads zero while running
        stop = 1'b0;
        hwrite(2'd0, 1'b0, 32'hAAAA_5555);
        hread(2'd0, rd);
        check("R9 read zero while running", rd, 32'h0);
        // R2: address increments by BIU command
        inc_addr = 1'b1; step(); step(); inc_addr = 1'b0;
        stop = 1'b1;
        hread(2'd0, rd);
        check("R9/R2 write ignored, two increments", rd, 32'h0000_0002);

        // R4: countdown of three bytes, done pulse, then blocking
        hwrite(2'd1, 1'b0, 32'h0000_0FFD);
        stop = 1'b0;
        inc_cnt = 1'b1;
        step(); check("R4 no done at FFE", {31'd0, buf_done}, 32'd0);
        step(); check("R4 no done at FFF", {31'd0, buf_done}, 32'd0);
        step(); check("R4 done at wrap", {31'd0, buf_done}, 32'd1);
        step(); check("R4 done one cycle", {31'd0, buf_done}, 32'd0);
        step(); inc_cnt = 1'b0;
        stop = 1'b1;
        hread(2'd1, rd);
        check("R4 blocked after wrap", rd, 32'h0000_F000);

        // R7: cycle limit 5, burst disabled
        hwrite(2'd2, 1'b0, 32'd5);
        hwrite(2'd3, 1'b0, 32'd0);
        stop = 1'b0; timer_en = 1'b1; bus_own = 1'b1;
        for (int k = 0; k < 5; k++) step();
        check("R7 no release before limit", {31'd0, bus_release}, 32'd0);
        step();
        check("R7 release at limit", {31'd0, bus_release}, 32'd1);
        step();
        check("R7 release held", {31'd0, bus_release}, 32'd1);
        bus_own = 1'b0; step();
        check("R7 release drops", {31'd0, bus_release}, 32'd0);

        // R8: burst of 3 beats under a long cycle limit
        stop = 1'b1;
        hwrite(2'd2, 1'b0, 32'd100);
        hwrite(2'd3, 1'b0, 32'd3);
        stop = 1'b0; bus_own = 1'b1;
        step();
        xfer = 1'b1;
        step(); step();
        check("R8 no release after two beats", {31'd0, bus_release}, 32'd0);
        step(); xfer = 1'b0;
        check("R8 release after third beat", {31'd0, bus_release}, 32'd1);
        bus_own = 1'b0; step();
        stop = 1'b1;
        hread(2'd3, rd);
        check("R8 burst counter at zero", rd, 32'd0);

        // R10: timer disabled, no release
        hwrite(2'd2, 1'b0, 32'd2);
        stop = 1'b0; timer_en = 1'b0; bus_own = 1'b1;
        for (int k = 0; k < 8; k++) step();
        check("R10 no release when disabled", {31'd0, bus_release}, 32'd0);
        bus_own = 1'b0; step();

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule